// File: doc/BRIEF.md
# RTC Interval Timer with Sticky Event Flag

This block is a periodic wake-up timer for a real-time clock. Software picks one of four clock-enable tick sources and loads an 8-bit interval. An 8-bit counter advances on each tick of the chosen source. When the counter reaches the interval, the block sets an event flag. The flag stays set until software clears it. While it is set, the flag drives a wake request, and also an interrupt request when the global interrupt enable is high.

A mode bit selects what happens after an event. In auto-restart mode the counter starts a new period. In single-shot mode the counter is held at zero. Changes to the enable bit, the timebase select and the interval value are staged. They take effect only on the next pulse of the slow RTC synchronisation tick. Read-back shows the values that are currently in force.

Software reaches the block through a small register port. The control register is at address 0. The interval register is at address 1.

Top module: `rtc_interval_timer`

## Requirements
- R1: After reset, both registers read 0, the counter is 0, and irq_o and wake_o are low.
- R2: When enabled, the counter advances once per pulse of tick_i[sel], where sel is the timebase field (control bits 5:4); encoding n selects tick_i[n]. The pulses of the other three tick inputs are ignored. On a selected tick where the counter equals the interval, an event fires, so the first event comes on the (interval+1)-th selected tick after the configuration takes effect. An interval of 0 fires on the first tick.
- R3: When the single-shot bit (control bit 3) is 0, the counter returns to 0 after each event, and every further interval+1 selected ticks produce another event.
- R4: When the single-shot bit is 1, the counter is held at 0 after an event and no further event occurs. Writing the single-shot bit to 0 releases the hold at once, and counting resumes from 0.
- R5: An event sets the flag (control bit 2). The flag stays set until a control write with bit 2 = 1. A control write with bit 2 = 0 leaves the flag unchanged. If an event and a clearing write happen in the same cycle, the flag stays set.
- R6: irq_o is high exactly when the flag is set and irq_en_i is high. A flag set while irq_en_i is low raises irq_o as soon as irq_en_i rises.
- R7: wake_o equals the flag and stays high until the flag is cleared.
- R8: A written enable bit (control bit 1), timebase select or interval value takes effect at the rising clock edge where sync_tick_i is high. Until then the block keeps operating on the old values, and read-back shows the old values. The single-shot bit and the flag clear act on the write itself.
- R9: While the enable bit in force is 0, the counter is held at 0 and no event occurs. Re-enabling starts a full period.
- R10: Unused control bits (0, 6, 7) read as 0. The interval register reads the interval value currently in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 4 | Single-cycle timebase tick enables, one per select code |
| sync_tick_i | input | 1 | Slow RTC tick that applies staged configuration |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 interval |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Pending interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The bench sweeps interval values over the low range and the top of the 8-bit range, and rotates through all four timebase codes. Between selected ticks it inserts a pulse on a tick input that is not selected. A design with an off-by-one match would raise the flag one tick early or late. A design that decodes the select wrongly would count the interleaved pulses.

Staging is probed in several ways:
- It reads back the enable bit before and after the sync tick.
- It sends ticks on the new source before the sync tick.
- It counts against the old interval after a new interval has been written but not yet applied.

It also checks these corner cases:
- The single-shot hold, and its release when the mode bit is cleared.
- A write with bit 2 = 0, which must not clear the flag.
- A clearing write in the same cycle as an event, where a design that gives the clear priority would lose the event.
- An interrupt that stays pending while irq_en_i is low.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned N_TB   = 4;
  localparam int unsigned TB_W   = $clog2(N_TB);
  localparam int unsigned DATA_W = 8;

  // control register field positions
  localparam int unsigned EN_BIT  = 1;
  localparam int unsigned FLG_BIT = 2;
  localparam int unsigned SS_BIT  = 3;
  localparam int unsigned TB_LSB  = 4;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_IVAL = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic            en;
    logic [TB_W-1:0] tb;
    logic [CNT_W-1:0] ival;
  } cfg_t;
endpackage

// File: rtl/rit_cfg_sync.sv
module rit_cfg_sync
  import rit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_tick_i,
  input  logic             ctrl_we_i,
  input  logic             ival_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic             single_o
);
  cfg_t staged_q, active_q;
  logic single_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      single_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        staged_q.en <= wdata_i[EN_BIT];
        staged_q.tb <= wdata_i[TB_LSB +: TB_W];
        single_q    <= wdata_i[SS_BIT];
      end
      if (ival_we_i) staged_q.ival <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          active_q <= '0;
    else if (sync_tick_i) active_q <= staged_q;
  end

  assign cfg_o    = active_q;
  assign single_o = single_q;

  // R8: active configuration moves only on the sync tick
  a_r8_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_tick_i |=> $stable(active_q));
endmodule

// File: rtl/rit_counter.sv
module rit_counter
  import rit_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_TB-1:0] tick_i,
  input  cfg_t            cfg_i,
  input  logic            single_i,
  output logic            event_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             sel_tick, hold, match;

  assign sel_tick = tick_i[cfg_i.tb];
  assign hold     = done_q & single_i;
  assign match    = (cnt_q == cfg_i.ival);
  assign event_o  = cfg_i.en & ~hold & sel_tick & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!cfg_i.en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (!single_i) done_q <= 1'b0;
      else if (event_o) done_q <= 1'b1;
      if (hold || event_o) cnt_q <= '0;
      else if (sel_tick)   cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> cnt_q == '0);
  a_r4_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && hold) |=> cnt_q == '0);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !hold && sel_tick && !match) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> cnt_q == '0);
endmodule

// File: rtl/rit_flag.sv
module rit_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (event_i) flag_q <= 1'b1;   // event beats clear
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
  assign wake_o = flag_q;

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> flag_q);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !event_i) |=> !flag_q);
endmodule

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer
  import rit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TB-1:0]   tick_i,
  input  logic              sync_tick_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              irq_en_i,
  output logic              irq_o,
  output logic              wake_o
);
  cfg_t cfg;
  logic single, evt, flag, ctrl_we, ival_we;

  assign ctrl_we = reg_we_i & (reg_addr_i == ADDR_CTRL);
  assign ival_we = reg_we_i & (reg_addr_i == ADDR_IVAL);

  rit_cfg_sync u_cfg (
    .clk_i, .rst_ni, .sync_tick_i,
    .ctrl_we_i(ctrl_we), .ival_we_i(ival_we), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .single_o(single)
  );

  rit_counter u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .cfg_i(cfg), .single_i(single), .event_o(evt)
  );

  rit_flag u_flag (
    .clk_i, .rst_ni, .event_i(evt),
    .clr_i(ctrl_we & reg_wdata_i[FLG_BIT]),
    .irq_en_i, .flag_o(flag), .irq_o, .wake_o
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_IVAL) begin
      reg_rdata_o[CNT_W-1:0] = cfg.ival;
    end else begin
      reg_rdata_o[EN_BIT]              = cfg.en;
      reg_rdata_o[FLG_BIT]             = flag;
      reg_rdata_o[SS_BIT]              = single;
      reg_rdata_o[TB_LSB +: TB_W]      = cfg.tb;
    end
  end

  a_r6_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);
endmodule

// File: tb/tb_rtc_interval_timer.sv
`timescale 1ns/1ps
module tb_rtc_interval_timer;
  logic clk = 0, rst_n = 0;
  logic [3:0] tick = 0;
  logic sync = 0, we = 0, addr = 0, irq_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_interval_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sync_tick_i(sync),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_en_i(irq_en), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    we = 1; addr = a; wdata = d; cyc(); we = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(int s);
    tick[s] = 1; cyc(); tick = 0;
  endtask

  task automatic do_sync();
    sync = 1; cyc(); sync = 0;
  endtask

  function automatic logic [7:0] ctl(bit en, int tb, bit ss, bit clr);
    return {2'b00, 2'(tb), ss, clr, en, 1'b0};
  endfunction

  task automatic setup(int iv, int tb, bit ss);
    wr(0, ctl(0, 0, 0, 1)); do_sync();
    wr(1, 8'(iv));
    wr(0, ctl(1, tb, ss, 1)); do_sync();
  endtask

  // run iv+1 selected ticks with foreign ticks interleaved; 1 if event timing right
  task automatic period(int iv, int tb, output bit ok);
    ok = 1;
    for (int k = 0; k <= iv; k++) begin
      if (wake !== 1'b0) ok = 0;
      pulse((tb + 1) % 4);
      pulse(tb);
    end
    if (wake !== 1'b1) ok = 0;
  endtask

  initial begin
    logic [7:0] d;
    bit ok;
    #5; rst_n = 1; cyc();
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 ival", d, 0);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);

    // R8 enable staged
    wr(1, 8'd2); wr(0, ctl(1, 0, 0, 0));
    rd(0, d); chk("R8 en before sync", d[1], 0);
    rd(1, d); chk("R8 ival before sync", d, 0);
    pulse(0); chk("R9 disabled no event", wake, 0);
    do_sync();
    rd(0, d); chk("R8 en after sync", d[1], 1);
    rd(1, d); chk("R8 ival after sync", d, 2);

    // R2/R3 sweep
    for (int iv = 0; iv < 300; iv++) begin
      if (iv > 40 && iv < 250) continue;
      if (iv > 255) break;
      setup(iv, iv % 4, 0);
      period(iv, iv % 4, ok); chk($sformatf("R2 first event iv=%0d", iv), ok, 1);
      wr(0, ctl(1, iv % 4, 0, 1));
      period(iv, iv % 4, ok); chk($sformatf("R3 restart iv=%0d", iv), ok, 1);
    end

    // R4 single shot
    setup(2, 1, 1);
    period(2, 1, ok); chk("R4 single first", ok, 1);
    wr(0, ctl(1, 1, 1, 1));
    for (int k = 0; k < 10; k++) pulse(1);
    chk("R4 held no event", wake, 0);
    wr(0, ctl(1, 1, 0, 0));
    period(2, 1, ok); chk("R4 release resumes from 0", ok, 1);

    // R5 / R6 / R7
    irq_en = 0; #1;
    chk("R6 irq masked", irq, 0); chk("R7 wake set", wake, 1);
    wr(0, ctl(1, 1, 0, 0));
    rd(0, d); chk("R5 write 0 keeps flag", d[2], 1);
    irq_en = 1; #1; chk("R6 pending delivered", irq, 1);
    wr(0, ctl(1, 1, 0, 1));
    chk("R5 clear flag", wake, 0); chk("R6 irq drops", irq, 0);

    // R5 event beats clear
    setup(0, 2, 0);
    we = 1; addr = 0; wdata = ctl(1, 2, 0, 1); tick[2] = 1; cyc(); we = 0; tick = 0;
    chk("R5 event wins over clear", wake, 1);
    chk("R7 wake follows flag", wake, 1);

    // R8 interval and timebase staged
    setup(3, 0, 0);
    wr(1, 8'd1);
    rd(1, d); chk("R8 old ival readback", d, 3);
    period(3, 0, ok); chk("R8 old ival in use", ok, 1);
    wr(0, ctl(1, 3, 0, 1));
    pulse(3); pulse(3); pulse(3); pulse(3); pulse(3);
    chk("R8 new timebase not yet active", wake, 0);
    do_sync();
    rd(0, d); chk("R8 tb after sync", d[5:4], 3);
    period(1, 3, ok); chk("R8 new ival and tb active", ok, 1);

    // R9 disable resets counter
    setup(3, 0, 0);
    pulse(0); pulse(0);
    wr(0, ctl(0, 0, 0, 0)); do_sync();
    wr(0, ctl(1, 0, 0, 0)); do_sync();
    period(3, 0, ok); chk("R9 full period after re-enable", ok, 1);

    // R10 unused bits
    wr(0, 8'hff); rd(0, d);
    chk("R10 unused bits zero", d & 8'hc1, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule